// File: doc/BRIEF.md
# Float64 Scaled-Fraction Rounder

This block rounds one double-precision value so that only a chosen count of binary places below the point remain, from none up to fifteen. The result is returned as a double. A control byte carries the count of kept places in its upper nibble, a two-bit rounding direction in its lowest bits, a bit that replaces that direction with a global two-bit mode input, and a bit that silences the inexact flag. A separate input enables flushing of denormal operands to zero.

The result is defined as 2^-M times the integer nearest (in the chosen direction) to x times 2^M. The scaled intermediate is never formed, so it cannot overflow. Instead, the bit position where rounding happens is derived from the operand's exponent and M. The result and both flags are registered, with one clock of latency, and a new operand may be presented on every clock.

Top module: `f64_rsf`

## Requirements
- R1: The result equals 2^-M x RoundToInt(x x 2^M), with M = ctrl_i[7:4] (0 to 15). It appears on res_o one clock edge after the operand is sampled.
- R2: The effective rounding direction is encoded as 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero.
- R3: When ctrl_i[2] is 1, the direction comes from gmode_i and ctrl_i[1:0] has no effect. When ctrl_i[2] is 0, gmode_i has no effect.
- R4: inexact_o is 1 exactly when ctrl_i[3] is 0 and the result differs from the operand. When ctrl_i[3] is 1, inexact_o stays 0.
- R5: A signaling NaN (exponent all ones, fraction nonzero, fraction bit 51 clear) is returned with fraction bit 51 set and raises invalid_o. Quiet NaNs and infinities are returned unchanged. invalid_o is 0 for every other operand.
- R6: When daz_i is 1, a denormal operand (exponent zero, fraction nonzero) becomes a zero of the same sign before rounding. It is then reported as exact.
- R7: The result keeps the operand's sign in every case. A negative value that rounds to zero gives -0.
- R8: When the unbiased exponent plus M is 52 or more, the operand is returned unchanged and reported as exact. This includes the largest finite values, and no infinity is ever produced from a finite operand.
- R9: When the magnitude lies below half a unit at 2^-M, the result is a signed zero. The exception is a direction that rounds away from zero (down for negative, up for positive), which gives a signed 2^-M. In nearest mode an exact half unit is a tie that goes to zero.
- R10: When rounding carries out of the significand, the exponent is incremented and the fraction cleared. For example, 0.999... rounded up gives exactly 1.0.
- R11: While rst_n is low, res_o, inexact_o and invalid_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| op_i | input | 64 | Double-precision operand |
| ctrl_i | input | 8 | [7:4] kept places M, [3] inexact silence, [2] use global mode, [1:0] direction |
| gmode_i | input | 2 | Global rounding direction, same encoding as ctrl_i[1:0] |
| daz_i | input | 1 | Flush denormal operands to signed zero |
| res_o | output | 64 | Rounded double |
| inexact_o | output | 1 | Result differs from operand |
| invalid_o | output | 1 | Operand was a signaling NaN |

## Verification
The hardest cases to reach are the narrow exponent bands where the rounding position falls exactly at, or just beyond, the top of the significand. One is an exact half unit at 2^-M that must tie to zero. Another is a carry out of an all-ones significand that must renormalize. Uniform random operands almost never land there. The stimulus therefore picks the exponent relative to 1023 - M, in a window a few positions either side of the significand edges. It masks random low fraction bits to zero so that ties and exact values appear often, and it adds directed operands for each band.

// File: rtl/f64_rsf_pkg.sv
package f64_rsf_pkg;

    localparam int EXP_W    = 11;
    localparam int FRAC_W   = 52;
    localparam int SCALE_W  = 4;
    localparam int CTL_W    = 8;
    localparam int SEL_BIT  = 2;
    localparam int SUP_BIT  = 3;
    localparam int WORD_W   = 1 + EXP_W + FRAC_W;
    localparam int SIG_W    = FRAC_W + 1;
    localparam int WIDE_W   = SIG_W + 1;
    localparam int POS_W    = $clog2(SIG_W + 1);
    localparam int KW       = EXP_W + 2;
    localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX  = (1 << EXP_W) - 1;

    typedef enum logic [1:0] {
        DIR_NEAR = 2'b00,
        DIR_DOWN = 2'b01,
        DIR_UP   = 2'b10,
        DIR_ZERO = 2'b11
    } dir_e;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_QNAN,
        CLS_SNAN
    } cls_e;

    typedef struct packed {
        logic [WORD_W-1:0] res;
        logic              inexact;
        logic              invalid;
    } out_t;

endpackage

// File: rtl/f64_rsf_unpack.sv
module f64_rsf_unpack
    import f64_rsf_pkg::*;
(
    input  logic [WORD_W-1:0]  op_i,
    input  logic [CTL_W-1:0]   ctrl_i,
    input  logic [1:0]         gmode_i,
    input  logic               daz_i,
    output cls_e               cls_o,
    output logic               sign_o,
    output logic [EXP_W-1:0]   exp_o,
    output logic [FRAC_W-1:0]  frac_o,
    output dir_e               dir_o,
    output logic [SCALE_W-1:0] scale_o,
    output logic               quiet_o
);

    logic [EXP_W-1:0]  raw_exp;
    logic [FRAC_W-1:0] raw_frac;

    always_comb begin
        raw_exp  = op_i[WORD_W-2:FRAC_W];
        raw_frac = op_i[FRAC_W-1:0];
        sign_o   = op_i[WORD_W-1];
        exp_o    = raw_exp;
        frac_o   = raw_frac;
        if (raw_exp == EXP_W'(EXP_MAX)) begin
            if (raw_frac == '0)
                cls_o = CLS_INF;
            else if (raw_frac[FRAC_W-1])
                cls_o = CLS_QNAN;
            else
                cls_o = CLS_SNAN;
        end else if (raw_exp == '0) begin
            if (raw_frac == '0) begin
                cls_o = CLS_ZERO;
            end else if (daz_i) begin
                cls_o  = CLS_ZERO;
                frac_o = '0;
            end else begin
                cls_o = CLS_SUB;
            end
        end else begin
            cls_o = CLS_NORM;
        end
    end

    always_comb begin
        dir_o   = ctrl_i[SEL_BIT] ? dir_e'(gmode_i) : dir_e'(ctrl_i[1:0]);
        scale_o = ctrl_i[CTL_W-1 -: SCALE_W];
        quiet_o = ctrl_i[SUP_BIT];
    end

endmodule

// File: rtl/f64_rsf_round.sv
module f64_rsf_round
    import f64_rsf_pkg::*;
(
    input  logic               sign_i,
    input  logic [EXP_W-1:0]   exp_i,
    input  logic [FRAC_W-1:0]  frac_i,
    input  logic               is_sub_i,
    input  dir_e               dir_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [WORD_W-1:0]  res_o,
    output logic               lost_o
);

    logic signed [KW-1:0] int_bits;
    logic signed [KW-1:0] shift_full;
    logic                 big;
    logic                 tiny;
    logic [POS_W-1:0]     sh;
    logic [WIDE_W-1:0]    wide;
    logic [WIDE_W-1:0]    kept;
    logic [WIDE_W-1:0]    below;
    logic [WIDE_W-1:0]    low_mask;
    logic [WIDE_W-1:0]    sum;
    logic [WIDE_W-1:0]    back;
    logic                 rbit;
    logic                 sticky;
    logic                 inc;
    logic                 away;

    // Position of the rounding point relative to the significand.
    always_comb begin
        int_bits   = $signed({2'b00, exp_i}) - KW'(BIAS)
                   + $signed({{(KW-SCALE_W){1'b0}}, scale_i});
        big        = int_bits >= KW'(FRAC_W);
        tiny       = is_sub_i || (int_bits < -KW'(1));
        shift_full = KW'(FRAC_W) - int_bits;
        sh         = (big || tiny) ? POS_W'(1) : shift_full[POS_W-1:0];
    end

    // Split into kept part, round bit and sticky bits.
    always_comb begin
        wide     = {1'b0, 1'b1, frac_i};
        kept     = wide >> sh;
        below    = wide >> (sh - POS_W'(1));
        rbit     = below[0];
        low_mask = (WIDE_W'(1) << (sh - POS_W'(1))) - WIDE_W'(1);
        sticky   = |(wide & low_mask);
        away     = ((dir_i == DIR_DOWN) && sign_i) || ((dir_i == DIR_UP) && !sign_i);
        unique case (dir_i)
            DIR_NEAR: inc = rbit && (sticky || kept[0]);
            DIR_DOWN: inc = (rbit || sticky) && sign_i;
            DIR_UP:   inc = (rbit || sticky) && !sign_i;
            default:  inc = 1'b0;
        endcase
        sum  = kept + WIDE_W'(inc);
        back = sum << sh;
    end

    // Reassemble the result.
    always_comb begin
        if (big) begin
            res_o  = {sign_i, exp_i, frac_i};
            lost_o = 1'b0;
        end else if (tiny) begin
            lost_o = 1'b1;
            if (away)
                res_o = {sign_i, EXP_W'(BIAS) - {{(EXP_W-SCALE_W){1'b0}}, scale_i},
                         {FRAC_W{1'b0}}};
            else
                res_o = {sign_i, {(WORD_W-1){1'b0}}};
        end else begin
            lost_o = rbit || sticky;
            if (back == '0)
                res_o = {sign_i, {(WORD_W-1){1'b0}}};
            else if (back[WIDE_W-1])
                res_o = {sign_i, exp_i + EXP_W'(1), {FRAC_W{1'b0}}};
            else
                res_o = {sign_i, exp_i, back[FRAC_W-1:0]};
        end
    end

endmodule

// File: rtl/f64_rsf.sv
module f64_rsf
    import f64_rsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       op_i,
    input  logic [7:0]        ctrl_i,
    input  logic [1:0]        gmode_i,
    input  logic              daz_i,
    output logic [63:0]       res_o,
    output logic              inexact_o,
    output logic              invalid_o
);

    cls_e               cls;
    logic               sign;
    logic [EXP_W-1:0]   exp_v;
    logic [FRAC_W-1:0]  frac_v;
    dir_e               dir;
    logic [SCALE_W-1:0] scale;
    logic               quiet;
    logic [WORD_W-1:0]  core_res;
    logic               core_lost;
    out_t               out_d;
    out_t               out_q;

    f64_rsf_unpack u_unpack (
        .op_i    (op_i),
        .ctrl_i  (ctrl_i),
        .gmode_i (gmode_i),
        .daz_i   (daz_i),
        .cls_o   (cls),
        .sign_o  (sign),
        .exp_o   (exp_v),
        .frac_o  (frac_v),
        .dir_o   (dir),
        .scale_o (scale),
        .quiet_o (quiet)
    );

    f64_rsf_round u_round (
        .sign_i   (sign),
        .exp_i    (exp_v),
        .frac_i   (frac_v),
        .is_sub_i (cls == CLS_SUB),
        .dir_i    (dir),
        .scale_i  (scale),
        .res_o    (core_res),
        .lost_o   (core_lost)
    );

    always_comb begin
        out_d = '0;
        unique case (cls)
            CLS_SUB, CLS_NORM: begin
                out_d.res     = core_res;
                out_d.inexact = core_lost && !quiet;
            end
            CLS_SNAN: begin
                out_d.res     = {sign, exp_v, 1'b1, frac_v[FRAC_W-2:0]};
                out_d.invalid = 1'b1;
            end
            default: begin
                out_d.res = {sign, exp_v, frac_v};
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign res_o     = out_q.res;
    assign inexact_o = out_q.inexact;
    assign invalid_o = out_q.invalid;

    // Checks: armed one edge after reset so that $past refers to sampled operands.
    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else
            armed_q <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) |-> (res_o == '0 && !inexact_o && !invalid_o)); // R11

    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        res_o[63] == $past(op_i[63])); // R7

    AST_SILENCED: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(ctrl_i[SUP_BIT]) |-> !inexact_o); // R4

    AST_INEXACT_CHANGED: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        inexact_o |-> (res_o != $past(op_i))); // R4

    AST_INVALID_SNAN: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        invalid_o |-> ($past(op_i[62:52]) == 11'h7FF && !$past(op_i[51])
                       && $past(op_i[50:0]) != '0 && res_o[51])); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (res_o[62:52] == 11'h7FF && res_o[51:0] == '0)
        |-> ($past(op_i[62:52]) == 11'h7FF && $past(op_i[51:0]) == '0)); // R8

    AST_DAZ_FLUSH: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(daz_i && op_i[62:52] == '0) |-> (res_o[62:0] == '0 && !inexact_o)); // R6

endmodule

// File: tb/f64_rsf_tb.sv
module f64_rsf_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    typedef struct packed {
        logic [63:0] res;
        logic        pe;
        logic        inv;
        logic [63:0] op;
        logic [7:0]  ctrl;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] op;
    logic [7:0]  ctrl;
    logic [1:0]  gmode;
    logic        daz;
    logic [63:0] res;
    logic        inexact;
    logic        invalid;

    int n_tests = 0;
    int n_fail  = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    f64_rsf u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .ctrl_i    (ctrl),
        .gmode_i   (gmode),
        .daz_i     (daz),
        .res_o     (res),
        .inexact_o (inexact),
        .invalid_o (invalid)
    );

    // Behavioural model built on real arithmetic.
    function automatic exp_t model(input logic [63:0] x, input logic [7:0] c,
                                   input logic [1:0] g, input logic d);
        exp_t  e;
        int    ex;
        int    m;
        logic [1:0] dir;
        real   xv, y, fl, r, z, sc;
        e      = '0;
        e.op   = x;
        e.ctrl = c;
        ex     = int'(x[62:52]);
        m      = int'(c[7:4]);
        dir    = c[2] ? g : c[1:0];
        if (ex == 2047) begin
            if (x[51:0] != 0 && !x[51]) begin
                e.res = x | 64'h0008_0000_0000_0000;
                e.inv = 1'b1;
            end else begin
                e.res = x;
            end
            return e;
        end
        if (ex == 0 && d) begin
            e.res = {x[63], 63'd0};
            return e;
        end
        if (ex != 0 && ex - 1023 + m >= 52) begin
            e.res = x;
            return e;
        end
        sc = 2.0 ** m;
        xv = $bitstoreal(x);
        y  = xv * sc;
        fl = $floor(y);
        case (dir)
            2'b00: begin
                if (y - fl > 0.5)      r = fl + 1.0;
                else if (y - fl < 0.5) r = fl;
                else r = ((fl / 2.0) == $floor(fl / 2.0)) ? fl : fl + 1.0;
            end
            2'b01:   r = fl;
            2'b10:   r = $ceil(y);
            default: r = (y < 0.0) ? $ceil(y) : fl;
        endcase
        z         = r / sc;
        e.res     = $realtobits(z);
        e.res[63] = x[63];
        e.pe      = (e.res != x) && !c[3];
        return e;
    endfunction

    function automatic string tag_for(input logic [63:0] x, input logic [7:0] c,
                                      input logic d);
        int ex;
        ex = int'(x[62:52]);
        if (ex == 2047) return "R5";
        if (ex == 0 && x[51:0] != 0 && d) return "R6";
        if (ex == 0 && x[51:0] != 0) return "R9";
        if (ex != 0 && ex - 1023 + int'(c[7:4]) >= 52) return "R8";
        if (ex != 0 && ex - 1023 + int'(c[7:4]) < -1) return "R9";
        if (c[3]) return "R4";
        if (c[2]) return "R3";
        return "R1";
    endfunction

    task automatic compare_pending();
        exp_t  e;
        string t;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_tests++;
        if (res !== e.res || inexact !== e.pe || invalid !== e.inv) begin
            n_fail++;
            $display("FAIL %s op=%h ctrl=%h got %h pe=%b inv=%b expected %h pe=%b inv=%b",
                     t, e.op, e.ctrl, res, inexact, invalid, e.res, e.pe, e.inv);
        end
    endtask

    task automatic apply(input logic [63:0] x, input logic [7:0] c,
                         input logic [1:0] g, input logic d, input string t);
        @(negedge clk);
        compare_pending();
        op    = x;
        ctrl  = c;
        gmode = g;
        daz   = d;
        exp_q.push_back(model(x, c, g, d));
        tag_q.push_back(t);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: got running expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        op    = 64'h4004_0000_0000_0000;
        ctrl  = 8'h02;
        gmode = 2'b00;
        daz   = 1'b0;
        repeat (3) @(negedge clk);
        // R11: outputs held at zero during reset
        n_tests++;
        if (res !== 64'd0 || inexact !== 1'b0 || invalid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 got %h pe=%b inv=%b expected 0 0 0", res, inexact, invalid);
        end
        rst_n = 1'b1;

        // R7 signed zeros and sign kept through rounding to zero
        apply(64'h0000_0000_0000_0000, 8'h00, 2'b00, 1'b0, "R7");
        apply(64'h8000_0000_0000_0000, 8'h32, 2'b00, 1'b0, "R7");
        apply(64'hBFD3_3333_3333_3333, 8'h02, 2'b00, 1'b0, "R7");
        apply(64'h3FD3_3333_3333_3333, 8'h01, 2'b00, 1'b0, "R7");
        // R5 special values
        apply(64'h7FF0_0000_0000_0000, 8'h02, 2'b00, 1'b0, "R5");
        apply(64'hFFF0_0000_0000_0000, 8'h01, 2'b00, 1'b0, "R5");
        apply(64'h7FF8_0000_0000_0001, 8'h00, 2'b00, 1'b0, "R5");
        apply(64'h7FF0_0000_0000_0001, 8'h00, 2'b00, 1'b0, "R5");
        apply(64'hFFF4_0000_0000_0000, 8'hF3, 2'b00, 1'b0, "R5");
        // R2 each direction on 2.5, -2.5 and 3.5
        for (int k = 0; k < 4; k++) begin
            apply(64'h4004_0000_0000_0000, 8'(k), 2'b00, 1'b0, "R2");
            apply(64'hC004_0000_0000_0000, 8'(k), 2'b00, 1'b0, "R2");
        end
        apply(64'h400C_0000_0000_0000, 8'h00, 2'b00, 1'b0, "R2");
        // R3 global mode select, and ignored when not selected
        apply(64'h4004_0000_0000_0000, 8'h04, 2'b10, 1'b0, "R3");
        apply(64'h4004_0000_0000_0000, 8'h07, 2'b00, 1'b0, "R3");
        apply(64'h4004_0000_0000_0000, 8'h00, 2'b10, 1'b0, "R3");
        // R4 suppressed inexact
        apply(64'h4004_0000_0000_0000, 8'h08, 2'b00, 1'b0, "R4");
        apply(64'h4004_0000_0000_0000, 8'h1A, 2'b00, 1'b0, "R4");
        // R10 carry out of the significand
        apply(64'h3FEF_FFFF_FFFF_FFFF, 8'h02, 2'b00, 1'b0, "R10");
        apply(64'h3FEF_FFFF_FFFF_FFFF, 8'hF2, 2'b00, 1'b0, "R10");
        apply(64'hC03F_FFFF_FFFF_FFFF, 8'h31, 2'b00, 1'b0, "R10");
        // R8 already representable values, including the largest finite
        apply(64'h7FEF_FFFF_FFFF_FFFF, 8'hF2, 2'b00, 1'b0, "R8");
        apply(64'h4330_0000_0000_0001, 8'h00, 2'b00, 1'b0, "R8");
        apply(64'h3FF0_0000_0000_0000, 8'hF0, 2'b00, 1'b0, "R1");
        // R9 tiny magnitudes, half-unit tie at maximum M
        apply(64'h3EF0_0000_0000_0000, 8'hF0, 2'b00, 1'b0, "R9");
        apply(64'h3EF0_0000_0000_0000, 8'hF2, 2'b00, 1'b0, "R9");
        apply(64'h3EF0_0000_0000_0001, 8'hF0, 2'b00, 1'b0, "R9");
        apply(64'hBEE0_0000_0000_0000, 8'hF1, 2'b00, 1'b0, "R9");
        apply(64'h0000_0000_0000_0001, 8'h02, 2'b00, 1'b0, "R9");
        apply(64'h8000_0000_0000_0001, 8'h01, 2'b00, 1'b0, "R9");
        // R6 denormals flushed
        apply(64'h0000_0000_0000_0001, 8'h02, 2'b00, 1'b1, "R6");
        apply(64'h800F_FFFF_FFFF_FFFF, 8'h01, 2'b00, 1'b1, "R6");

        // R1 random operands with exponents near the rounding edges
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [63:0] x;
            logic [7:0]  c;
            logic [1:0]  g;
            logic        d;
            int          ex;
            int          sel;
            c   = 8'($urandom);
            g   = 2'($urandom);
            d   = ($urandom % 4) == 0;
            x   = {$urandom, $urandom};
            sel = int'($urandom % 8);
            if ($urandom % 2 == 0)
                x[51:0] = x[51:0] & ~((52'd1 << ($urandom % 52)) - 52'd1);
            if (sel == 1) begin
                x[62:52] = 11'd0;
            end else if (sel >= 2) begin
                ex = 1023 - int'(c[7:4]) + int'($urandom % 60) - 6;
                if (ex < 1) ex = 1;
                if (ex > 2046) ex = 2046;
                x[62:52] = 11'(ex);
            end
            apply(x, c, g, d, tag_for(x, c, d));
        end
        @(negedge clk);
        compare_pending();
        finish_run();
    end

endmodule